// File: doc/BRIEF.md
# S-Record Text Stream Parser

This block turns a stream of received ASCII characters, one byte per valid cycle, into memory write transactions. It reads the characters as Motorola S-record text. For every data byte of a data record it issues one write that carries a byte address and an 8-bit value. It decodes hex digits, dispatches on the record type, keeps track of the remaining byte count, assembles the address and accumulates a checksum. A bad checksum sets a sticky error flag.

The block sits between a serial receiver and the memory write path of a small system. Its `busy_o` output is raised by the first record that is not a terminator. It stays high until a terminator record has been fully received. While `busy_o` is high, the processor is held in reset, so the processor only starts once the image has been loaded.

Top module: `srec_parser`

## Requirements
- R1: While `rst_ni` is low, `wr_en_o`, `wr_addr_o`, `wr_data_o`, `busy_o` and `cksum_err_o` are all zero.
- R2: Hex digits are accepted as `0`-`9` (0x30-0x39), `A`-`F` (0x41-0x46) and `a`-`f` (0x61-0x66). Upper and lower case give the same value.
- R3: A record is `S`, a type digit, a two-digit byte count, the address, the data bytes and a checksum byte. For type digits `1`, `2` and `3` (4, 6 or 8 address digits), each data byte produces exactly one `wr_en_o` pulse. The pulse appears in the cycle after the valid cycle that carried the second digit of that byte, with `wr_data_o` equal to the byte.
- R4: The first write of a record uses the record address, zero-extended to 32 bits. Each further write in the same record uses the previous address plus one.
- R5: Records of type `0` and `5` (4 address digits) are parsed in full, including the checksum, but produce no writes.
- R6: `busy_o` rises in the cycle after an accepted type digit `0`, `1`, `2`, `3` or `5`. It falls in the cycle after the last checksum digit of a type `7`, `8` or `9` terminator (8, 6 and 4 address digits). No other event changes it.
- R7: The expected checksum is the bitwise inverse of the low byte of the sum of the count, address and data bytes. If the received checksum differs, `cksum_err_o` is set in the cycle after its last digit and stays set until reset.
- R8: A byte presented while `rx_valid_i` is low has no effect. Between records, CR, LF and any character other than `S` are ignored.
- R9: A non-hex character inside a record abandons that record: it produces no further writes and no checksum check. An `S` anywhere starts a new record at once.
- R10: A record whose byte count is smaller than its number of address bytes plus one is dropped without writes or a checksum check.
- R11: `wr_en_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | `rx_byte_i` holds a new character this cycle |
| rx_byte_i | input | 8 | Received ASCII character |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | ADDR_W | Byte address of the write |
| wr_data_o | output | 8 | Data byte of the write |
| busy_o | output | 1 | Loading in progress; used to hold the processor in reset |
| cksum_err_o | output | 1 | Sticky checksum mismatch flag |

## Verification
Every result is registered once, so it is due in the cycle after the valid cycle that completes it:
- a write after the second digit of a data byte;
- the busy rise after the type digit;
- the busy fall and the error flag after the last checksum digit.

The bench drives each character for one cycle at a falling edge and samples the outputs at the next falling edge. It checks that `wr_en_o` matches the expectation for that exact character, so a write that comes late, early or twice is reported. Random gaps with a junk byte on the bus separate characters. Records with random types, lengths, addresses and letter case are mixed with directed aborted, resynchronised, short-count, bad-checksum and terminator records.

// File: rtl/srec_pkg.sv
package srec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TYPE, ST_CNT, ST_ADDR, ST_DATA, ST_CK
  } st_e;

  typedef enum logic [1:0] {
    RK_INFO, RK_DATA, RK_TERM
  } kind_e;

  localparam logic [7:0] CH_S = 8'h53;

  typedef struct packed {
    logic       ok;
    kind_e      kind;
    logic [2:0] nab;   // address bytes
  } rtype_t;

  function automatic rtype_t decode_type(input logic [7:0] ch);
    rtype_t r;
    r = '{ok: 1'b1, kind: RK_INFO, nab: 3'd2};
    case (ch)
      8'h30, 8'h35: r = '{ok: 1'b1, kind: RK_INFO, nab: 3'd2};
      8'h31:        r = '{ok: 1'b1, kind: RK_DATA, nab: 3'd2};
      8'h32:        r = '{ok: 1'b1, kind: RK_DATA, nab: 3'd3};
      8'h33:        r = '{ok: 1'b1, kind: RK_DATA, nab: 3'd4};
      8'h37:        r = '{ok: 1'b1, kind: RK_TERM, nab: 3'd4};
      8'h38:        r = '{ok: 1'b1, kind: RK_TERM, nab: 3'd3};
      8'h39:        r = '{ok: 1'b1, kind: RK_TERM, nab: 3'd2};
      default:      r.ok = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/srec_hex_decode.sv
module srec_hex_decode (
  input  logic [7:0] ch_i,
  output logic       hex_o,
  output logic [3:0] val_o
);
  logic [7:0] t;
  always_comb begin
    hex_o = 1'b1;
    t     = 8'd0;
    if (ch_i >= 8'h30 && ch_i <= 8'h39)      t = ch_i - 8'h30;
    else if (ch_i >= 8'h41 && ch_i <= 8'h46) t = ch_i - 8'h37;
    else if (ch_i >= 8'h61 && ch_i <= 8'h66) t = ch_i - 8'h57;
    else                                     hex_o = 1'b0;
    val_o = t[3:0];
  end
endmodule

// File: rtl/srec_cksum.sv
module srec_cksum #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] sum_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_q + byte_i;
  end
  assign sum_o = sum_q;
endmodule

// File: rtl/srec_parser.sv
module srec_parser
  import srec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o,
  output logic              cksum_err_o
);
  localparam int REC_AW = 32;
  localparam int BYTE_W = 8;

  st_e               state_q;
  kind_e             kind_q;
  logic [2:0]        nab_q, acnt_q;
  logic [BYTE_W-1:0] left_q;
  logic [3:0]        hi_q;
  logic              half_q;
  logic [REC_AW-1:0] addr_q;
  logic              wr_en_q, busy_q, err_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;

  logic              is_hex;
  logic [3:0]        nib;
  logic [BYTE_W-1:0] full_byte, sum, left_m1;
  logic              in_byte_st, byte_done, is_s;
  rtype_t            rt;

  srec_hex_decode u_hex (.ch_i(rx_byte_i), .hex_o(is_hex), .val_o(nib));

  assign is_s       = rx_byte_i == CH_S;
  assign rt         = decode_type(rx_byte_i);
  assign full_byte  = {hi_q, nib};
  assign left_m1    = left_q - 8'd1;
  assign in_byte_st = state_q inside {ST_CNT, ST_ADDR, ST_DATA, ST_CK};
  assign byte_done  = rx_valid_i && !is_s && in_byte_st && is_hex && half_q;

  srec_cksum #(.W(BYTE_W)) u_ck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rx_valid_i && state_q == ST_TYPE && rt.ok),
    .add_i  (byte_done && state_q != ST_CK),
    .byte_i (full_byte),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RK_INFO;
      nab_q     <= 3'd0;
      acnt_q    <= 3'd0;
      left_q    <= '0;
      hi_q      <= 4'd0;
      half_q    <= 1'b0;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (rx_valid_i) begin
        if (is_s) begin
          state_q <= ST_TYPE;
          half_q  <= 1'b0;
        end else if (state_q == ST_TYPE) begin
          half_q <= 1'b0;
          if (rt.ok) begin
            state_q <= ST_CNT;
            kind_q  <= rt.kind;
            nab_q   <= rt.nab;
            if (rt.kind != RK_TERM) busy_q <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end else if (in_byte_st) begin
          if (!is_hex) begin
            state_q <= ST_IDLE;
          end else if (!half_q) begin
            hi_q   <= nib;
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            case (state_q)
              ST_CNT: begin
                left_q <= full_byte;
                addr_q <= '0;
                acnt_q <= 3'd0;
                state_q <= (full_byte < ({5'd0, nab_q} + 8'd1)) ? ST_IDLE : ST_ADDR;
              end
              ST_ADDR: begin
                addr_q <= {addr_q[REC_AW-BYTE_W-1:0], full_byte};
                left_q <= left_m1;
                acnt_q <= acnt_q + 3'd1;
                if (acnt_q + 3'd1 == nab_q)
                  state_q <= (left_m1 == 8'd1) ? ST_CK : ST_DATA;
              end
              ST_DATA: begin
                if (kind_q == RK_DATA) begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= addr_q[ADDR_W-1:0];
                  wr_data_q <= full_byte;
                end
                addr_q <= addr_q + 1'b1;
                left_q <= left_m1;
                if (left_m1 == 8'd1) state_q <= ST_CK;
              end
              default: begin  // ST_CK
                if (full_byte != ~sum) err_q <= 1'b1;
                if (kind_q == RK_TERM) busy_q <= 1'b0;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
      end
    end
  end

  assign wr_en_o     = wr_en_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign busy_o      = busy_q;
  assign cksum_err_o = err_q;

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R11
  AST_WR_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o); // R6
  AST_WR_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rx_valid_i)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cksum_err_o |=> cksum_err_o); // R7
  AST_BUSY_FALL_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(rx_valid_i && state_q == ST_CK && kind_q == RK_TERM)); // R6
endmodule

// File: tb/tb_srec_parser.sv
module tb_srec_parser;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        rx_valid_i;
  logic [7:0]  rx_byte_i;
  logic        wr_en_o;
  logic [31:0] wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        busy_o, cksum_err_o;

  always #10 clk_i = ~clk_i;

  srec_parser #(.ADDR_W(32)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit exp_busy = 1'b0, exp_err = 1'b0;
  logic [7:0] dat [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lc);
    if (n < 4'd10) return 8'h30 + {4'd0, n};
    return (lc ? 8'h61 : 8'h41) + {4'd0, n} - 8'd10;
  endfunction

  // one character, then check the write due one cycle later
  task automatic put(input logic [7:0] c, input bit ew = 1'b0,
                     input logic [31:0] ea = '0, input logic [7:0] ed = '0);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_byte_i  = c;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    rx_byte_i  = 8'($urandom);  // junk while not valid, R8
    chk(wr_en_o == ew, "R3/R11", "wr_en", {31'd0, wr_en_o}, {31'd0, ew});
    if (ew) begin
      chk(wr_addr_o == ea, "R4", "wr_addr", wr_addr_o, ea);
      chk(wr_data_o == ed, "R3", "wr_data", {24'd0, wr_data_o}, {24'd0, ed});
    end
    repeat ($urandom_range(0, 2)) @(negedge clk_i);
  endtask

  task automatic put_hex(input logic [7:0] b, input bit lc, input bit ew = 1'b0,
                         input logic [31:0] ea = '0);
    put(hexc(b[7:4], lc));
    put(hexc(b[3:0], lc), ew, ea, b);
  endtask

  task automatic send_rec(input int typ, input logic [31:0] addr_in, input int n,
                          input bit lc, input bit bad);
    int nab;
    logic [7:0] cnt, sum, ck;
    logic [31:0] addr;
    bit term, wdat;
    nab  = (typ == 2 || typ == 8) ? 3 : (typ == 3 || typ == 7) ? 4 : 2;
    addr = (nab == 2) ? {16'd0, addr_in[15:0]} : (nab == 3) ? {8'd0, addr_in[23:0]} : addr_in;
    term = typ >= 7;
    wdat = typ >= 1 && typ <= 3;
    cnt  = 8'(nab + n + 1);
    sum  = cnt;
    put(8'h53);
    put(8'h30 + 8'(typ));
    if (!term) exp_busy = 1'b1;
    chk(busy_o == exp_busy, "R6", "busy after type", {31'd0, busy_o}, {31'd0, exp_busy});
    put_hex(cnt, lc);
    for (int i = nab - 1; i >= 0; i--) begin
      sum = sum + addr[8*i +: 8];
      put_hex(addr[8*i +: 8], lc);
    end
    for (int i = 0; i < n; i++) begin
      sum = sum + dat[i];
      put_hex(dat[i], lc, wdat, addr + 32'(i));
    end
    ck = ~sum;
    if (bad) begin
      ck = ck ^ 8'h5A;
      exp_err = 1'b1;
    end
    put_hex(ck, lc);
    if (term) exp_busy = 1'b0;
    chk(busy_o == exp_busy, "R6", "busy after record", {31'd0, busy_o}, {31'd0, exp_busy});
    chk(cksum_err_o == exp_err, "R7", "cksum_err", {31'd0, cksum_err_o}, {31'd0, exp_err});
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0; rx_valid_i = 1'b0; rx_byte_i = 8'h53;
    repeat (3) @(negedge clk_i);
    chk(!wr_en_o && !busy_o && !cksum_err_o, "R1", "flags in reset",
        {29'd0, wr_en_o, busy_o, cksum_err_o}, 32'd0);
    chk(wr_addr_o == 0 && wr_data_o == 0, "R1", "write bus in reset", wr_addr_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o, "R1", "busy after reset", {31'd0, busy_o}, 32'd0);

    // R8: noise between records
    put(8'h0D); put(8'h0A); put(8'h20); put(8'h31);
    // R5: header record
    fill(6); send_rec(0, 32'h0000, 6, 1'b0, 1'b0);

    // R2 R3 R4: random data records
    for (int k = 0; k < 24; k++) begin
      int typ, n;
      typ = $urandom_range(1, 3);
      n   = $urandom_range(0, 12);
      fill(n);
      send_rec(typ, $urandom, n, 1'($urandom), 1'b0);
      if ($urandom_range(0, 1) == 1) begin put(8'h0D); put(8'h0A); end
    end
    // R4: 16-bit address crossing
    fill(4); send_rec(1, 32'h0000FFFE, 4, 1'b1, 1'b0);
    // R5: count record
    fill(3); send_rec(5, 32'h0003, 3, 1'b0, 1'b0);

    // R9: non-hex char abandons the record
    put(8'h53); put(8'h31); put_hex(8'h05, 0); put_hex(8'h20, 0); put_hex(8'h00, 0);
    put_hex(8'h11, 0, 1'b1, 32'h2000);
    put(8'h78);
    put_hex(8'h22, 0); put_hex(8'h00, 0);
    chk(cksum_err_o == 1'b0, "R9", "no check after abort", {31'd0, cksum_err_o}, 32'd0);
    // R9: S inside a record restarts
    put(8'h53); put(8'h31); put_hex(8'h06, 1); put_hex(8'h30, 1); put_hex(8'h00, 1);
    put_hex(8'hAB, 1, 1'b1, 32'h3000);
    fill(2); send_rec(1, 32'h4000, 2, 1'b1, 1'b0);
    // R10: short count drops the record
    put(8'h53); put(8'h32); put_hex(8'h03, 0);
    put_hex(8'h12, 0); put_hex(8'h34, 0); put_hex(8'h56, 0); put_hex(8'h77, 0);
    chk(cksum_err_o == 1'b0, "R10", "dropped record unchecked", {31'd0, cksum_err_o}, 32'd0);
    chk(busy_o == 1'b1, "R10", "busy held", {31'd0, busy_o}, 32'd1);

    // R6: terminator ends loading
    send_rec(9, 32'h0000, 0, 1'b0, 1'b0);
    // R7: bad checksum, then sticky
    fill(5); send_rec(2, 32'h00ABCDEF, 5, 1'b0, 1'b1);
    fill(3); send_rec(3, 32'h80001000, 3, 1'b1, 1'b0);
    send_rec(8, 32'h00123456, 0, 1'b0, 1'b0);
    fill(2); send_rec(1, 32'h0100, 2, 1'b0, 1'b0);
    send_rec(7, 32'h80000000, 0, 1'b1, 1'b0);
    repeat (3) @(negedge clk_i);
    chk(cksum_err_o == 1'b1, "R7", "sticky error", {31'd0, cksum_err_o}, 32'd1);
    chk(busy_o == 1'b0, "R6", "busy idle at end", {31'd0, busy_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule